// File: doc/BRIEF.md
# Timer Time-Base Counter

This block is the counting core of a general-purpose timer. A 16-bit counter advances on a prescaled tick input while it is enabled. It either counts in one direction and wraps at a programmable reload limit, or it counts up and down in alternation (center-aligned). Each wrap, a software update request and an external update request can raise an update event. The event may also reload a buffered limit value, raise a request flag for an interrupt or DMA engine, and stop the counter in single-pulse operation.

A simple write/read port reaches two registers. Select 0 is a 10-bit control word and select 1 is the reload limit. Beside the count, the block drives a count-direction status and a qualifier that tells the compare channels when their flags may be set. It also drives a sampling-clock enable divided down from the timer clock.

The count direction is held in a two-state machine with states RISE and FALL. In edge mode the state copies the stored direction bit on every cycle. In center-aligned modes two transitions are used. RISE goes to FALL on the top hit, and FALL goes to RISE on the bottom hit. Neither transition fires on a cycle where a forced update reinitialises the counter.

Top module: `tbase_unit`

## Requirements
- R1: After reset the control word reads 0 and the reload limit reads 0. The count is 0, direction reads up, the update outputs are low, and the compare qualifier and sampling enable are high.
- R2: The counter changes only on cycles where control bit 0 (enable) is 1 and `tick` is 1. A forced update is the one exception.
- R3: With alignment field bits 6:5 = 0, control bit 4 selects the direction (0 up, 1 down). Up: a tick at count >= limit gives 0 and a counter event. Down: a tick at count 0 loads the limit and gives a counter event.
- R4: With bits 6:5 nonzero, counting alternates direction. Rising: a tick where count+1 >= limit increments and switches to falling, with a counter event. Falling: a tick at count <= 1 gives 0 and switches to rising, with a counter event. Bit 4 reads the live direction and writes to it are ignored.
- R5: With control bit 1 (update disable) = 1, no update event or request is produced and the buffered limit is not transferred.
- R6: With control bit 2 (update source) = 0, every update event also pulses `upd_req`. With bit 2 = 1, only counter events pulse it.
- R7: With control bit 3 (single pulse) = 1, an update event clears the enable bit. A control write in the same cycle takes priority.
- R8: With control bit 7 (shadow) = 1, a written limit takes effect at the next update event. With bit 7 = 0 it takes effect at once.
- R9: A pulse on `sw_upd` or `ext_upd` with updates allowed reinitialises the counter: to 0 when counting up, to the written limit when counting down. It is an update event in the following cycle.
- R10: `cmp_ok` is always 1 in modes 0 and 3. In mode 1 it is 1 only while falling, and in mode 2 only while rising.
- R11: Control bits 9:8 give `samp_en` a period of 1, 2 or 4 clocks for codes 0, 1 and 2. Code 3 behaves as code 0.
- R12: `upd_evt`/`upd_req` are registered: they are high in the cycle after the event condition, together with the updated count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count tick |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = reload limit |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| sw_upd | input | 1 | Software update-generate request |
| ext_upd | input | 1 | External update request |
| count_o | output | 16 | Counter value |
| upd_evt | output | 1 | Update event pulse |
| upd_req | output | 1 | Interrupt/DMA update request pulse |
| dir_o | output | 1 | 1 while counting down |
| cmp_ok | output | 1 | Compare flags permitted |
| samp_en | output | 1 | Divided sampling-clock enable |

## Verification
The checker watches on every cycle that the count holds while disabled and that update disable silences both pulses. It also checks that a request never comes without an event, that a forced update while rising clears the count, and that an edge-mode up wrap lands on 0 with an event. It further covers the single-pulse self-disable and the compare qualifier in mode 1. Only the bench's scenarios show the full center-aligned sequences, the delayed effect of the buffered limit, and the direction-dependent reload value of a forced update. The same holds for the request filtering by source and the divider periods, which the bench compares cycle by cycle against its own model under seeded random traffic.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int CTL_W = 10;
    localparam int DIV_W = 2;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_t;

    // Field order follows the bit positions of the control word (MSB first).
    typedef struct packed {
        logic [1:0] div;
        logic       shd;
        logic [1:0] aln;
        logic       dir;
        logic       one;
        logic       usrc;
        logic       udis;
        logic       en;
    } ctl_t;
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             evt_nx,
    output ctl_t             ctl,
    output logic [CNT_W-1:0] arr_buf,
    output logic [CNT_W-1:0] arr_eff
);
    logic [CNT_W-1:0] arr_act;
    ctl_t             ctl_new;

    always_comb begin
        ctl_new = ctl_t'(wdata[CTL_W-1:0]);
        if (ctl_new.aln != 2'b00) ctl_new.dir = ctl.dir;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= '0;
            arr_buf <= '0;
            arr_act <= '0;
        end else begin
            if (wr && !sel)              ctl    <= ctl_new;
            else if (evt_nx && ctl.one)  ctl.en <= 1'b0;
            if (wr && sel)               arr_buf <= wdata;
            if (evt_nx)                  arr_act <= arr_buf;
        end
    end

    assign arr_eff = ctl.shd ? arr_act : arr_buf;
endmodule

// File: rtl/tbase_fsm.sv
module tbase_fsm
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             udis,
    input  logic             dir,
    input  logic [1:0]       aln,
    input  logic [CNT_W-1:0] arr_eff,
    input  logic [CNT_W-1:0] arr_buf,
    input  logic             force_req,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             ctr_evt,
    output logic             go
);
    localparam logic [CNT_W:0]   ONE_X = 1;
    localparam logic [CNT_W-1:0] ONE_N = 1;

    phase_t           phase_q, phase_d;
    logic             center, step, up_hit, dn_hit;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] reload;

    assign center  = (aln != 2'b00);
    assign step    = en & tick;
    assign go      = force_req & ~udis;
    assign down    = center ? (phase_q == PH_FALL) : dir;
    assign cnt_inc = {1'b0, cnt} + ONE_X;
    assign up_hit  = center ? (cnt_inc >= {1'b0, arr_eff}) : (cnt >= arr_eff);
    assign dn_hit  = center ? (cnt <= ONE_N) : (cnt == '0);
    assign ctr_evt = step & ~go & (down ? dn_hit : up_hit);
    assign reload  = udis ? arr_eff : arr_buf;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_RISE;
        else        phase_q <= phase_d;
    end

    // next state
    always_comb begin
        phase_d = phase_q;
        if (!center) begin
            phase_d = dir ? PH_FALL : PH_RISE;
        end else if (step && !go) begin
            unique case (phase_q)
                PH_RISE: if (up_hit) phase_d = PH_FALL;
                PH_FALL: if (dn_hit) phase_d = PH_RISE;
            endcase
        end
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (go) begin
            cnt <= down ? arr_buf : '0;
        end else if (step) begin
            if (!down)       cnt <= (up_hit && !center) ? '0 : cnt_inc[CNT_W-1:0];
            else if (dn_hit) cnt <= center ? '0 : reload;
            else             cnt <= cnt - ONE_N;
        end
    end
endmodule

// File: rtl/tbase_samp.sv
module tbase_samp
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] code,
    output logic             samp_en
);
    logic [DIV_W-1:0] dcnt, mask;

    always_comb begin
        unique case (code)
            2'd1:    mask = 2'b01;
            2'd2:    mask = 2'b11;
            default: mask = 2'b00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dcnt <= '0;
        else        dcnt <= dcnt + 2'd1;
    end

    assign samp_en = ((dcnt & mask) == '0);
endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             sw_upd,
    input  logic             ext_upd,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_evt,
    output logic             upd_req,
    output logic             dir_o,
    output logic             cmp_ok,
    output logic             samp_en
);
    ctl_t             ctl, ctl_rd;
    logic [CNT_W-1:0] arr_buf, arr_eff;
    logic             down, ctr_evt, go, evt_nx, req_nx, force_req;

    assign force_req = sw_upd | ext_upd;
    assign evt_nx    = ~ctl.udis & (ctr_evt | force_req);
    assign req_nx    = evt_nx & (~ctl.usrc | ctr_evt);

    tbase_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .evt_nx(evt_nx), .ctl(ctl), .arr_buf(arr_buf), .arr_eff(arr_eff)
    );

    tbase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl.en), .udis(ctl.udis),
        .dir(ctl.dir), .aln(ctl.aln), .arr_eff(arr_eff), .arr_buf(arr_buf),
        .force_req(force_req), .cnt(count_o), .down(down), .ctr_evt(ctr_evt), .go(go)
    );

    tbase_samp i_samp (.clk(clk), .rst_n(rst_n), .code(ctl.div), .samp_en(samp_en));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_evt <= 1'b0;
            upd_req <= 1'b0;
        end else begin
            upd_evt <= evt_nx;
            upd_req <= req_nx;
        end
    end

    always_comb begin
        ctl_rd     = ctl;
        ctl_rd.dir = down;
        unique case (ctl.aln)
            2'd1:    cmp_ok = down;
            2'd2:    cmp_ok = ~down;
            default: cmp_ok = 1'b1;
        endcase
    end

    assign dir_o     = down;
    assign reg_rdata = reg_sel ? arr_buf : {{(CNT_W-CTL_W){1'b0}}, ctl_rd};
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             reg_wr,
    input logic             sw_upd,
    input logic             ext_upd,
    input ctl_t             ctl,
    input logic [CNT_W-1:0] arr_eff,
    input logic [CNT_W-1:0] count_o,
    input logic             upd_evt,
    input logic             upd_req,
    input logic             dir_o,
    input logic             cmp_ok,
    input logic             samp_en
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.en && !sw_upd && !ext_upd) |=> (count_o == $past(count_o))); // R2
    AST_EDGE_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.aln == 2'd0 && !ctl.dir && ctl.en && tick && !ctl.udis && !sw_upd && !ext_upd
         && count_o >= arr_eff) |=> (count_o == '0 && upd_evt)); // R3
    AST_QUIET_UDIS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.udis |=> (!upd_evt && !upd_req)); // R5
    AST_REQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> upd_evt); // R6
    AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.one && !ctl.udis && sw_upd && !reg_wr) |=> !ctl.en); // R7
    AST_FORCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd && !ctl.udis && !dir_o) |=> (count_o == '0)); // R9
    AST_CMP_MODE1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.aln == 2'd1 && cmp_ok) |-> dir_o); // R10
    AST_SAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.div == 2'd0) |-> samp_en); // R11
endmodule

bind tbase_unit tbase_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .sw_upd(sw_upd),
    .ext_upd(ext_upd), .ctl(ctl), .arr_eff(arr_eff), .count_o(count_o),
    .upd_evt(upd_evt), .upd_req(upd_req), .dir_o(dir_o), .cmp_ok(cmp_ok),
    .samp_en(samp_en)
);

// File: tb/test_tbase_unit.sv
module test_tbase_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata, count_o;
    logic        sw_upd = 1'b0, ext_upd = 1'b0, upd_evt, upd_req, dir_o, cmp_ok, samp_en;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    int m_cnt, m_buf, m_act, m_dcnt, m_cam, m_div;
    bit m_ph, m_en, m_udis, m_ups, m_spm, m_dir, m_arse, m_evt, m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_unit i_tbase_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_upd(sw_upd), .ext_upd(ext_upd),
        .count_o(count_o), .upd_evt(upd_evt), .upd_req(upd_req), .dir_o(dir_o),
        .cmp_ok(cmp_ok), .samp_en(samp_en)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit e_down();
        return (m_cam != 0) ? m_ph : m_dir;
    endfunction

    function automatic bit e_cmp();
        case (m_cam)
            1: return e_down();
            2: return !e_down();
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit e_samp();
        int mask = (m_div == 1) ? 1 : (m_div == 2) ? 3 : 0;
        return (m_dcnt & mask) == 0;
    endfunction

    function automatic int e_ctl();
        return (m_div << 8) | (int'(m_arse) << 7) | (m_cam << 5) | (int'(e_down()) << 4)
             | (int'(m_spm) << 3) | (int'(m_ups) << 2) | (int'(m_udis) << 1) | int'(m_en);
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_buf = 0; m_act = 0; m_dcnt = 0; m_cam = 0; m_div = 0;
        m_ph = 0; m_en = 0; m_udis = 0; m_ups = 0; m_spm = 0; m_dir = 0; m_arse = 0;
        m_evt = 0; m_req = 0;
    endtask

    task automatic model_step();
        bit center = (m_cam != 0);
        bit down = e_down();
        bit frc = sw_upd | ext_upd;
        bit go = frc && !m_udis;
        bit step = m_en && tick;
        int lim = m_arse ? m_act : m_buf;
        bit uph = center ? (m_cnt + 1 >= lim) : (m_cnt >= lim);
        bit dnh = center ? (m_cnt <= 1) : (m_cnt == 0);
        bit wrap = step && !go && (down ? dnh : uph);
        bit evt = !m_udis && (wrap || frc);
        int old_buf = m_buf;
        int ncnt = m_cnt;
        bit nph = m_ph;
        if (go) ncnt = down ? m_buf : 0;
        else if (step) begin
            if (!down) ncnt = (uph && !center) ? 0 : ((m_cnt + 1) & 16'hFFFF);
            else if (dnh) ncnt = center ? 0 : (m_udis ? lim : m_buf);
            else ncnt = m_cnt - 1;
        end
        if (!center) nph = m_dir;
        else if (step && !go) begin
            if (!m_ph && uph) nph = 1;
            else if (m_ph && dnh) nph = 0;
        end
        m_cnt = ncnt; m_ph = nph;
        m_req = evt && (!m_ups || wrap);
        m_evt = evt;
        if (reg_wr && !reg_sel) begin
            m_en = reg_wdata[0]; m_udis = reg_wdata[1]; m_ups = reg_wdata[2];
            m_spm = reg_wdata[3]; m_cam = int'(reg_wdata[6:5]);
            m_arse = reg_wdata[7]; m_div = int'(reg_wdata[9:8]);
            if (reg_wdata[6:5] == 2'd0) m_dir = reg_wdata[4];
        end else if (evt && m_spm) m_en = 0;
        if (reg_wr && reg_sel) m_buf = int'(reg_wdata);
        if (evt) m_act = old_buf;
        m_dcnt = (m_dcnt + 1) & 3;
    endtask

    task automatic compare_all();
        chk("R2 R3 R4 R8 R9 count", int'(count_o), m_cnt);
        chk("R5 R12 upd_evt", int'(upd_evt), int'(m_evt));
        chk("R6 upd_req", int'(upd_req), int'(m_req));
        chk("R4 dir_o", int'(dir_o), int'(e_down()));
        chk("R10 cmp_ok", int'(cmp_ok), int'(e_cmp()));
        chk("R11 samp_en", int'(samp_en), int'(e_samp()));
        chk("R7 R12 reg_rdata", int'(reg_rdata), reg_sel ? m_buf : e_ctl());
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        reg_wr = 0; sw_upd = 0; ext_upd = 0;
    endtask

    task automatic wr_reg(bit sel, int val);
        reg_wr = 1; reg_sel = sel; reg_wdata = 16'(val);
        cyc();
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) #1;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 ctl read", int'(reg_rdata), 0);
        chk("R1 evt/req", int'(upd_evt | upd_req), 0);
        chk("R1 dir/cmp/samp", int'({dir_o, cmp_ok, samp_en}), 3);

        // R3: edge up, limit 3, four ticks wrap to 0 with an event
        wr_reg(1, 3);
        reg_sel = 0;
        wr_reg(0, 16'h0001);
        tick = 1;
        repeat (4) cyc();
        chk("R3 wrap count", int'(count_o), 0);
        chk("R3 wrap event", int'(upd_evt), 1);

        // R7: single pulse stops after the next wrap
        wr_reg(0, 16'h0009);
        repeat (4) cyc();
        chk("R7 enable cleared", int'(reg_rdata[0]), 0);
        repeat (3) cyc();
        chk("R2 held while off", int'(count_o), 0);

        // R4: center mode 3, limit 3: 1,2,3(top),2,1,0(bottom)
        wr_reg(0, 16'h0061);
        repeat (3) cyc();
        chk("R4 peak count", int'(count_o), 3);
        chk("R4 falling", int'(dir_o), 1);
        repeat (3) cyc();
        chk("R4 bottom count", int'(count_o), 0);
        chk("R4 rising again", int'(dir_o), 0);

        // R8: shadow on, new limit waits for an update event
        wr_reg(0, 16'h0081);
        wr_reg(1, 6);
        sw_upd = 1; cyc();
        chk("R9 forced clear", int'(count_o), 0);
        wr_reg(1, 2);
        repeat (5) cyc();
        chk("R8 old limit still used", int'(count_o) > 2, 1);

        // R6: update source 1 filters forced updates from the request
        wr_reg(0, 16'h0005);
        ext_upd = 1; cyc();
        chk("R6 evt without req", int'({upd_evt, upd_req}), 2);

        // R5: update disabled
        wr_reg(0, 16'h0003);
        sw_upd = 1; cyc();
        chk("R5 no event", int'(upd_evt), 0);

        // seeded random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            tick = ($urandom % 4) != 0;
            reg_sel = $urandom % 2;
            if ($urandom % 30 == 0) begin
                int v;
                v = int'(($urandom % 8) != 0) | (int'(($urandom % 8) == 0) << 1)
                  | (int'($urandom % 2) << 2) | (int'(($urandom % 16) == 0) << 3)
                  | (int'($urandom % 2) << 4) | (int'($urandom % 4) << 5)
                  | (int'($urandom % 2) << 7) | (int'($urandom % 4) << 8);
                reg_wr = 1; reg_sel = 0; reg_wdata = 16'(v);
            end else if ($urandom % 25 == 0) begin
                reg_wr = 1; reg_sel = 1; reg_wdata = 16'($urandom % 10);
            end
            sw_upd = ($urandom % 40) == 0;
            ext_upd = ($urandom % 60) == 0;
            cyc();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule